// File: doc/BRIEF.md
# Single-Message Receive Buffer with Overrun Policy

This block sits behind the receive side of a LIN-style serial controller and holds one completed message for software: its identifier, a byte count and up to eight data bytes. The receive logic presents a one-cycle completion strobe together with the message and an error indication. A message that arrives with its error indication set is thrown away and changes nothing. Any other message is valid and is captured into the buffer, which then reads as full until software pulses the release strobe.

If a valid message completes while the buffer still holds an unreleased message, one of the two messages is lost. The block records this in a sticky overrun flag, which stays set until software pulses a write-one-to-clear strobe. A lock-mode input decides which message survives. With lock mode off, the new message overwrites the stored one, so software always sees the latest traffic. With lock mode on, the new message is dropped and the stored message is left untouched. A release that arrives in the same cycle as a valid message is handled first, so that case is an ordinary store and not an overrun.

All outputs come from registers and change one clock after the strobe that causes them.

Top module: `lin_rx_msgbuf`

## Requirements
- R1: After reset, buf_full_o and buf_ovr_o are 0, and buf_id_o, buf_len_o and buf_data_o are all zero.
- R2: A valid message (rx_done_i=1, rx_err_i=0) that arrives while the buffer is empty appears on buf_id_o, buf_len_o and buf_data_o one clock later, and buf_full_o goes to 1 in that same cycle.
- R3: Data byte k is held in bits [8k+7:8k] of buf_data_o. Every byte whose index is equal to or greater than the stored length reads as zero, so a length of 0 gives all-zero data.
- R4: A message that arrives with rx_err_i=1 changes neither the stored identifier, length and data nor buf_full_o and buf_ovr_o, whether the buffer is empty or full.
- R5: A valid message that arrives while buf_full_o=1, with no release in the same cycle, sets buf_ovr_o one clock later, and buf_full_o stays at 1.
- R6: During an overrun with lock_mode_i=0, the new message replaces the stored one.
- R7: During an overrun with lock_mode_i=1, the new message is discarded and the stored identifier, length and data stay unchanged.
- R8: buf_ovr_o stays at 1 until ovr_clr_i is pulsed, and clears one clock after that pulse. If an overrun and ovr_clr_i occur in the same cycle, the flag stays set.
- R9: A pulse on sw_release_i with no valid message in the same cycle clears buf_full_o one clock later. The stored contents remain visible.
- R10: When sw_release_i and a valid message occur in the same cycle, the new message is stored, buf_full_o stays at 1 and no overrun is flagged, in either lock mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_mode_i | input | 1 | 1 = keep the stored message on overrun, 0 = overwrite it |
| rx_done_i | input | 1 | One-cycle strobe: a message has completed |
| rx_err_i | input | 1 | The completing message had a protocol error |
| rx_id_i | input | 6 | Identifier of the completing message |
| rx_len_i | input | 4 | Number of data bytes, 0 to 8 |
| rx_data_i | input | 64 | Data bytes, byte k in bits [8k+7:8k] |
| sw_release_i | input | 1 | Software strobe that empties the buffer |
| ovr_clr_i | input | 1 | Software write-one-to-clear strobe for the overrun flag |
| buf_full_o | output | 1 | The buffer holds an unreleased message |
| buf_ovr_o | output | 1 | Sticky overrun flag |
| buf_id_o | output | 6 | Stored identifier |
| buf_len_o | output | 4 | Stored byte count |
| buf_data_o | output | 64 | Stored data, with unused bytes zeroed |

## Verification
Every output is a register, so a wrong full or overrun state shows at the ports in the cycle right after the strobe that caused it. The next valid arrival then makes it worse. A lost full bit turns an overrun into a silent overwrite with buf_ovr_o still low. A stuck full bit raises a false overrun and, in lock mode, drops a message that should have been stored. Wrong store gating shows at once as a changed or unchanged identifier that does not match the lock setting. A flag cleared too early shows as buf_ovr_o falling one idle cycle after it was set.

// File: rtl/lin_rxbuf_pkg.sv
// Shared constants and the message record for the receive buffer.
// Assumes at most eight data bytes and a six-bit identifier.
package lin_rxbuf_pkg;
    localparam int unsigned MAX_BYTES = 8;
    localparam int unsigned ID_W      = 6;
    localparam int unsigned LEN_W     = $clog2(MAX_BYTES + 1);
    localparam int unsigned DATA_W    = MAX_BYTES * 8;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } rx_msg_t;
endpackage

// File: rtl/lin_rxbuf_ctrl.sv
// Decides whether an arriving message is stored and keeps the full and
// overrun flags. Assumes every strobe is one cycle wide and synchronous.
// A release is applied before the arrival that shares its cycle.
module lin_rxbuf_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_mode_i,
    input  logic rx_done_i,
    input  logic rx_err_i,
    input  logic sw_release_i,
    input  logic ovr_clr_i,
    output logic store_o,
    output logic full_o,
    output logic ovr_o
);
    logic valid_msg;
    logic occupied;
    logic overrun;

    // Classify the arrival against the occupancy that remains after any release.
    always_comb begin
        valid_msg = rx_done_i && !rx_err_i;
        occupied  = full_o && !sw_release_i;
        overrun   = valid_msg && occupied;
        store_o   = valid_msg && (!occupied || !lock_mode_i);
    end

    // Track occupancy: a store fills the buffer, a release empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)            full_o <= 1'b0;
        else if (store_o)      full_o <= 1'b1;
        else if (sw_release_i) full_o <= 1'b0;
    end

    // Sticky overrun flag; a new overrun wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr_o <= 1'b0;
        else if (overrun)   ovr_o <= 1'b1;
        else if (ovr_clr_i) ovr_o <= 1'b0;
    end
endmodule

// File: rtl/lin_rxbuf_store.sv
// Message storage register. Loads the arriving record when store_i is set
// and zeroes every data byte at or beyond the reported length.
module lin_rxbuf_store
    import lin_rxbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    store_i,
    input  rx_msg_t msg_i,
    output rx_msg_t msg_o
);
    logic [DATA_W-1:0] masked_data;

    // Gate each byte lane with its own comparison against the length.
    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
        always_comb begin
            masked_data[8*k +: 8] = (LEN_W'(k) < msg_i.len) ? msg_i.data[8*k +: 8] : 8'h00;
        end
    end

    // Hold the record; load a new one only when the control unit asks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_o <= '0;
        end else if (store_i) begin
            msg_o.id   <= msg_i.id;
            msg_o.len  <= msg_i.len;
            msg_o.data <= masked_data;
        end
    end
endmodule

// File: rtl/lin_rx_msgbuf.sv
// Top level of the single-message receive buffer. Joins the store decision
// with the storage register. Assumes the receive logic reports one finished
// message per strobe and drives a length of 0 to 8.
module lin_rx_msgbuf
    import lin_rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_mode_i,
    input  logic              rx_done_i,
    input  logic              rx_err_i,
    input  logic [ID_W-1:0]   rx_id_i,
    input  logic [LEN_W-1:0]  rx_len_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              sw_release_i,
    input  logic              ovr_clr_i,
    output logic              buf_full_o,
    output logic              buf_ovr_o,
    output logic [ID_W-1:0]   buf_id_o,
    output logic [LEN_W-1:0]  buf_len_o,
    output logic [DATA_W-1:0] buf_data_o
);
    logic    store;
    rx_msg_t in_msg;
    rx_msg_t held_msg;

    // Pack the incoming fields and unpack the held record.
    always_comb begin
        in_msg.id   = rx_id_i;
        in_msg.len  = rx_len_i;
        in_msg.data = rx_data_i;
        buf_id_o    = held_msg.id;
        buf_len_o   = held_msg.len;
        buf_data_o  = held_msg.data;
    end

    lin_rxbuf_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_mode_i  (lock_mode_i),
        .rx_done_i    (rx_done_i),
        .rx_err_i     (rx_err_i),
        .sw_release_i (sw_release_i),
        .ovr_clr_i    (ovr_clr_i),
        .store_o      (store),
        .full_o       (buf_full_o),
        .ovr_o        (buf_ovr_o)
    );

    lin_rxbuf_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .store_i (store),
        .msg_i   (in_msg),
        .msg_o   (held_msg)
    );
endmodule

// File: rtl/lin_rxbuf_chk.sv
// Property checker for lin_rx_msgbuf, attached to it by the bind below.
// It only observes the ports.
module lin_rxbuf_chk
    import lin_rxbuf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lock_mode_i,
    input logic              rx_done_i,
    input logic              rx_err_i,
    input logic [ID_W-1:0]   rx_id_i,
    input logic [LEN_W-1:0]  rx_len_i,
    input logic [DATA_W-1:0] rx_data_i,
    input logic              sw_release_i,
    input logic              ovr_clr_i,
    input logic              buf_full_o,
    input logic              buf_ovr_o,
    input logic [ID_W-1:0]   buf_id_o,
    input logic [LEN_W-1:0]  buf_len_o,
    input logic [DATA_W-1:0] buf_data_o
);
    logic good;
    assign good = rx_done_i && !rx_err_i;

    // R2
    valid_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> buf_full_o);

    // R4
    err_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && rx_err_i && !sw_release_i && !ovr_clr_i) |=>
        ($stable(buf_full_o) && $stable(buf_ovr_o) && $stable(buf_id_o)
         && $stable(buf_len_o) && $stable(buf_data_o)));

    // R5
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good && buf_full_o && !sw_release_i) |=> (buf_ovr_o && buf_full_o));

    // R6
    unlocked_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good && buf_full_o && !sw_release_i && !lock_mode_i) |=>
        (buf_id_o == $past(rx_id_i) && buf_len_o == $past(rx_len_i)));

    // R7
    locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good && buf_full_o && !sw_release_i && lock_mode_i) |=>
        ($stable(buf_id_o) && $stable(buf_len_o) && $stable(buf_data_o)));

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_ovr_o && !ovr_clr_i) |=> buf_ovr_o);

    // R9
    release_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_release_i && !good) |=> (!buf_full_o && $stable(buf_id_o)));

    // R10
    release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_release_i && good && !buf_ovr_o) |=>
        (!buf_ovr_o && buf_full_o && buf_id_o == $past(rx_id_i)));
endmodule

bind lin_rx_msgbuf lin_rxbuf_chk u_chk (.*);

// File: tb/lin_rx_msgbuf_bench.sv
// Directed bench for lin_rx_msgbuf: one task per scenario, each checking itself.
module lin_rx_msgbuf_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_mode_i = 1'b0;
    logic        rx_done_i = 1'b0;
    logic        rx_err_i = 1'b0;
    logic [5:0]  rx_id_i = '0;
    logic [3:0]  rx_len_i = '0;
    logic [63:0] rx_data_i = '0;
    logic        sw_release_i = 1'b0;
    logic        ovr_clr_i = 1'b0;
    logic        buf_full_o;
    logic        buf_ovr_o;
    logic [5:0]  buf_id_o;
    logic [3:0]  buf_len_o;
    logic [63:0] buf_data_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    lin_rx_msgbuf u_lin_rx_msgbuf (.*);

    localparam logic [63:0] PAT_A = 64'h8877_6655_4433_2211;
    localparam logic [63:0] PAT_B = 64'hF0E1_D2C3_B4A5_9687;

    // Expected data: bytes at or beyond the length read as zero.
    function automatic logic [63:0] trim(input logic [63:0] d, input int len);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++) if (k < len) r[8*k +: 8] = d[8*k +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    // Drive one cycle of strobes at the falling edge, sample after the rising edge.
    task automatic step(input bit done, input bit err, input logic [5:0] id, input logic [3:0] len,
                        input logic [63:0] data, input bit rel, input bit clr);
        @(negedge clk);
        rx_done_i = done; rx_err_i = err; rx_id_i = id; rx_len_i = len; rx_data_i = data;
        sw_release_i = rel; ovr_clr_i = clr;
        @(posedge clk);
        #1;
        rx_done_i = 1'b0; rx_err_i = 1'b0; sw_release_i = 1'b0; ovr_clr_i = 1'b0;
    endtask

    task automatic idle();
        step(0, 0, 6'h0, 4'd0, 64'h0, 0, 0);
    endtask

    task automatic t_reset();
        chk_eq("R1 full", buf_full_o, 0);
        chk_eq("R1 ovr", buf_ovr_o, 0);
        chk_eq("R1 id", buf_id_o, 0);
        chk_eq("R1 len", buf_len_o, 0);
        chk_eq("R1 data", buf_data_o, 0);
    endtask

    task automatic t_store_release();
        lock_mode_i = 1'b0;
        step(1, 0, 6'h15, 4'd8, PAT_A, 0, 0);
        chk_eq("R2 full", buf_full_o, 1);
        chk_eq("R2 id", buf_id_o, 6'h15);
        chk_eq("R2 len", buf_len_o, 8);
        chk_eq("R2 data", buf_data_o, PAT_A);
        step(0, 0, 6'h0, 4'd0, 64'h0, 1, 0);
        chk_eq("R9 full cleared", buf_full_o, 0);
        chk_eq("R9 id kept", buf_id_o, 6'h15);
        chk_eq("R9 data kept", buf_data_o, PAT_A);
    endtask

    task automatic t_mask();
        step(1, 0, 6'h03, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
        chk_eq("R3 len3 data", buf_data_o, 64'h0000_0000_00FF_FFFF);
        step(0, 0, 6'h0, 4'd0, 64'h0, 1, 0);
        step(1, 0, 6'h04, 4'd0, PAT_B, 0, 0);
        chk_eq("R3 len0 data", buf_data_o, 0);
        step(0, 0, 6'h0, 4'd0, 64'h0, 1, 0);
        step(1, 0, 6'h05, 4'd5, PAT_B, 0, 0);
        chk_eq("R3 len5 data", buf_data_o, trim(PAT_B, 5));
        step(0, 0, 6'h0, 4'd0, 64'h0, 1, 0);
    endtask

    task automatic t_error();
        step(1, 1, 6'h2A, 4'd4, PAT_B, 0, 0);
        chk_eq("R4 empty full", buf_full_o, 0);
        chk_eq("R4 empty id", buf_id_o, 6'h05);
        step(1, 0, 6'h11, 4'd8, PAT_A, 0, 0);
        step(1, 1, 6'h22, 4'd2, PAT_B, 0, 0);
        chk_eq("R4 full id", buf_id_o, 6'h11);
        chk_eq("R4 full data", buf_data_o, PAT_A);
        chk_eq("R4 full ovr", buf_ovr_o, 0);
        chk_eq("R4 full flag", buf_full_o, 1);
        step(0, 0, 6'h0, 4'd0, 64'h0, 1, 0);
    endtask

    task automatic t_overwrite();
        lock_mode_i = 1'b0;
        step(1, 0, 6'h01, 4'd8, PAT_A, 0, 0);
        step(1, 0, 6'h02, 4'd6, PAT_B, 0, 0);
        chk_eq("R5 ovr set", buf_ovr_o, 1);
        chk_eq("R5 full kept", buf_full_o, 1);
        chk_eq("R6 id new", buf_id_o, 6'h02);
        chk_eq("R6 data new", buf_data_o, trim(PAT_B, 6));
        idle();
        chk_eq("R8 ovr sticky", buf_ovr_o, 1);
        step(0, 0, 6'h0, 4'd0, 64'h0, 0, 1);
        chk_eq("R8 ovr cleared", buf_ovr_o, 0);
        step(0, 0, 6'h0, 4'd0, 64'h0, 1, 0);
    endtask

    task automatic t_lock();
        lock_mode_i = 1'b1;
        step(1, 0, 6'h31, 4'd8, PAT_A, 0, 0);
        step(1, 0, 6'h32, 4'd2, PAT_B, 0, 0);
        chk_eq("R7 id kept", buf_id_o, 6'h31);
        chk_eq("R7 len kept", buf_len_o, 8);
        chk_eq("R7 data kept", buf_data_o, PAT_A);
        chk_eq("R5 ovr locked", buf_ovr_o, 1);
        step(1, 0, 6'h33, 4'd1, PAT_B, 0, 1);
        chk_eq("R8 set wins", buf_ovr_o, 1);
        chk_eq("R7 id still kept", buf_id_o, 6'h31);
        step(0, 0, 6'h0, 4'd0, 64'h0, 0, 1);
        chk_eq("R8 clear", buf_ovr_o, 0);
    endtask

    task automatic t_same_cycle();
        lock_mode_i = 1'b1;
        step(1, 0, 6'h3C, 4'd7, PAT_B, 1, 0);
        chk_eq("R10 lock id", buf_id_o, 6'h3C);
        chk_eq("R10 lock full", buf_full_o, 1);
        chk_eq("R10 lock ovr", buf_ovr_o, 0);
        lock_mode_i = 1'b0;
        step(1, 0, 6'h0C, 4'd8, PAT_A, 1, 0);
        chk_eq("R10 unlock id", buf_id_o, 6'h0C);
        chk_eq("R10 unlock ovr", buf_ovr_o, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_store_release();
        t_mask();
        t_error();
        t_overwrite();
        t_lock();
        t_same_cycle();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule